// File: doc/BRIEF.md
# Latched-Address Inverting Scratchpad RAM

This block is a 16-word by 4-bit read/write scratchpad with a single-clock model of an older asynchronous memory interface. A low-active select input and a low-active write input drive it. The block captures the address only on the cycle where the select input goes from high to low. While the select stays low, that captured location can be read, written, or read and then rewritten.

Reads return the bitwise inverse of the stored word and never change the array. In place of tri-state pins, the block has a 4-bit data output and an output-valid flag. The data output is zero whenever the flag is low. The flag is low during writes and whenever the block is not selected.

A host uses the block by presenting an address and lowering the select input. It then holds the write input low to store data, or high to read back.

Top module: `inv_scratch_ram`

## Requirements
- R1: After reset, `rdValid` is 0 and `rdData` is 0 while `selN` is high. Reset also sets the select history high, so the first low level of `selN` after reset counts as a falling edge.
- R2: The address register loads `addrIn` only in a cycle where `selN` is 0 and `selN` was 1 in the previous cycle. Changes on `addrIn` while `selN` stays low do not affect which word is read or written.
- R3: In every cycle with `selN`=0 and `wrN`=0, the array stores `wrData` at the selected address at the next rising clock edge.
- R4: In a cycle with `selN`=0 and `wrN`=1, `rdValid` is 1 and `rdData` equals the bitwise complement of the word at the selected address.
- R5: A read leaves the stored word unchanged, so repeated reads of a location return the same value.
- R6: `rdValid` is 0 and `rdData` is 0 whenever `selN` is 1 or `wrN` is 0.
- R7: With `selN` held low, `wrN` may toggle between reading and writing. All of these accesses go to the one captured location, and no new address is latched.
- R8: A read in the cycle that follows a write returns the complement of the data just written.
- R9: In the falling-edge cycle itself, the selected address is the current `addrIn`. A read or write in that cycle already goes to the new location.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| addrIn | input | 4 | Word address, captured on a select falling edge |
| wrData | input | 4 | Data to store |
| selN | input | 1 | Memory select, active low |
| wrN | input | 1 | Write command, active low |
| rdData | output | 4 | Inverted read word, zero when not valid |
| rdValid | output | 1 | Read data valid; stands in for the output drivers being on |

## Verification
The bench moves `addrIn` while the select stays low. A design that re-captures the address on the level of the select, rather than on its edge, would then return the wrong word. It runs a read-modify-write sequence and then reads the untouched neighbouring address. This exposes a write that lands on the live pins instead of the captured address. It checks the output flag and data during writes and while deselected, and checks inversion on the very first cycle of selection. An off-by-one-cycle address bypass would show stale data in that first cycle.

// File: rtl/scratch_pkg.sv
package scratch_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic latchAddr; // capture addrIn into the address register
    logic useLive;   // route addrIn directly this cycle (edge cycle)
    logic writeEn;   // commit wrData at next rising edge
    logic readEn;    // present inverted word and valid flag
  } ramStrobes_t;
endpackage

// File: rtl/scratch_ctrl.sv
module scratch_ctrl
  import scratch_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        selN,
  input  logic        wrN,
  output ramStrobes_t strb
);
  logic selHist;
  logic selFall;

  // Select history resets high so a first low level counts as an edge
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) selHist <= 1'b1;
    else       selHist <= selN;
  end

  assign selFall = selHist & ~selN;

  always_comb begin
    strb.latchAddr = selFall;
    strb.useLive   = selFall;
    strb.writeEn   = ~selN & ~wrN;
    strb.readEn    = ~selN &  wrN;
  end

  // Armed one cycle after reset so $past sees only post-reset values
  logic chkArmed;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chkArmed <= 1'b0;
    else       chkArmed <= 1'b1;
  end

  // R2 / R7: holding select low never re-latches the address
  a_r7_no_relatch: assert property (@(posedge clk) disable iff (!rstN)
    (chkArmed && !selN && !$past(selN)) |-> !strb.latchAddr);

  // R6: never read and write at once
  a_r6_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.readEn && strb.writeEn));
endmodule

// File: rtl/scratch_dpath.sv
module scratch_dpath
  import scratch_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  ramStrobes_t       strb,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [ADDR_W-1:0]             addrReg;
  logic [ADDR_W-1:0]             selAddr;
  logic [DEPTH-1:0][DATA_W-1:0]  memArr;
  logic [DATA_W-1:0]             rawWord;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               addrReg <= '0;
    else if (strb.latchAddr) addrReg <= addrIn;
  end

  assign selAddr = strb.useLive ? addrIn : addrReg;

  // Storage has no reset: contents undefined until written
  always_ff @(posedge clk) begin
    if (strb.writeEn) memArr[selAddr] <= wrData;
  end

  assign rawWord = memArr[selAddr];

  // Per-bit inversion and gating of the read path
  for (genvar b = 0; b < DATA_W; b++) begin : g_rdBit
    assign rdData[b] = strb.readEn & ~rawWord[b];
  end
  assign rdValid = strb.readEn;

  // R2: address register only moves on a latch strobe
  a_r2_addr_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strb.latchAddr |=> $stable(addrReg));

  // R5: array untouched without a write strobe
  a_r5_nondestructive: assert property (@(posedge clk) disable iff (!rstN)
    !strb.writeEn |=> $stable(memArr));

  // R3: a write strobe lands the data at the selected address
  a_r3_write_lands: assert property (@(posedge clk) disable iff (!rstN)
    strb.writeEn |=> memArr[$past(selAddr)] == $past(wrData));
endmodule

// File: rtl/inv_scratch_ram.sv
module inv_scratch_ram
  import scratch_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              selN,
  input  logic              wrN,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid
);
  ramStrobes_t strb;

  scratch_ctrl u_ctrl (
    .clk  (clk),
    .rstN (rstN),
    .selN (selN),
    .wrN  (wrN),
    .strb (strb)
  );

  scratch_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dpath (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .addrIn  (addrIn),
    .wrData  (wrData),
    .rdData  (rdData),
    .rdValid (rdValid)
  );

  // R6: outputs off while deselected or writing
  a_r6_outputs_off: assert property (@(posedge clk) disable iff (!rstN)
    (selN || !wrN) |-> (!rdValid && rdData == '0));
endmodule

// File: tb/tb_inv_scratch_ram.sv
module tb_inv_scratch_ram;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [3:0] addrIn = '0;
  logic [3:0] wrData = '0;
  logic       selN = 1'b1;
  logic       wrN = 1'b1;
  logic [3:0] rdData;
  logic       rdValid;

  int total = 0;
  int bad = 0;
  logic [3:0] model [16];

  always #5 clk = ~clk;

  inv_scratch_ram dut (
    .clk(clk), .rstN(rstN), .addrIn(addrIn), .wrData(wrData),
    .selN(selN), .wrN(wrN), .rdData(rdData), .rdValid(rdValid)
  );

  task automatic chk(input string req, input logic expV, input logic [3:0] expD);
    total++;
    if (rdValid !== expV || rdData !== expD) begin
      bad++;
      $display("FAIL %s: rdValid=%0b rdData=%h expected rdValid=%0b rdData=%h",
               req, rdValid, rdData, expV, expD);
    end
  endtask

  // Drive at falling edge, settle, then caller checks before next rise
  task automatic step(input logic s, input logic w, input logic [3:0] a, input logic [3:0] d);
    @(negedge clk);
    selN = s; wrN = w; addrIn = a; wrData = d;
    #2;
    if (!s && !w) model[a] = model[a]; // model updated by callers
  endtask

  task automatic doWrite(input logic [3:0] a, input logic [3:0] d);
    step(1, 1, a, d);
    chk("R6 deselected", 0, 4'h0);
    step(0, 0, a, d);                // edge cycle write, R9
    chk("R6 writing", 0, 4'h0);
    model[a] = d;
  endtask

  task automatic doRead(input string req, input logic [3:0] a);
    step(1, 1, a, 4'h0);
    step(0, 1, a, 4'h0);             // edge cycle read, R9
    chk(req, 1, ~model[a]);
  endtask

  task automatic testReset();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #2;
    chk("R1 reset outputs", 0, 4'h0);
    // First low after reset counts as an edge: R1
    step(0, 0, 4'h2, 4'h6);
    model[2] = 4'h6;
    step(0, 1, 4'h2, 4'h0);
    chk("R1 first low selects", 1, ~4'h6);
  endtask

  task automatic testWriteRead();
    for (int i = 0; i < 16; i++) doWrite(i[3:0], 4'(i * 5 + 3));
    for (int i = 0; i < 16; i++) doRead("R3 R4 R9 readback", i[3:0]);
  endtask

  task automatic testAddrHold();
    step(1, 1, 4'h5, 4'h0);
    step(0, 1, 4'h5, 4'h0);
    chk("R2 read at latched 5", 1, ~model[5]);
    step(0, 1, 4'h9, 4'h0);
    chk("R2 pins moved, still 5", 1, ~model[5]);
    step(0, 0, 4'hC, 4'hE);          // write goes to 5, not C
    model[5] = 4'hE;
    step(0, 1, 4'hC, 4'h0);
    chk("R2 write went to latched", 1, ~4'hE);
    doRead("R2 location C untouched", 4'hC);
  endtask

  task automatic testRmw();
    step(1, 1, 4'h3, 4'h0);
    step(0, 1, 4'h3, 4'h0);
    chk("R7 rmw read", 1, ~model[3]);
    step(0, 0, 4'h7, 4'hA);
    chk("R6 rmw writing", 0, 4'h0);
    model[3] = 4'hA;
    step(0, 1, 4'h7, 4'h0);
    chk("R8 read after write", 1, ~4'hA);
    step(0, 0, 4'h7, 4'h1);
    model[3] = 4'h1;
    step(0, 1, 4'h7, 4'h0);
    chk("R7 second rewrite", 1, ~4'h1);
    doRead("R7 neighbour 7 untouched", 4'h7);
  endtask

  task automatic testNonDestructive();
    for (int i = 0; i < 4; i++) doRead("R5 repeated read", 4'hB);
    step(0, 1, 4'hB, 4'h0);
    chk("R5 held read", 1, ~model[11]);
    step(1, 1, 4'hB, 4'h0);
    chk("R6 deselect after read", 0, 4'h0);
  endtask

  initial begin
    fork
      begin
        testReset();
        testWriteRead();
        testAddrHold();
        testRmw();
        testNonDestructive();
      end
      begin
        #200000;
        bad++;
        total++;
        $display("FAIL watchdog: run hung, actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule